// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the eight-bit status word of a small eight-bit processor core. Five of its bits are condition flags that the arithmetic unit and data moves update: carry, zero, overflow and negative, plus a break marker written when an interrupt is entered. The other three are control bits: an interrupt mask, a decimal-arithmetic select and a memory-to-memory mode select. The core's decoder drives per-flag update strobes, one flag command per cycle, a bit-test operand path, an interrupt-entry pulse and a full parallel restore. The register returns the packed word for a stack push, each flag on its own for branch decisions, an interrupt-accept signal, the two mode controls and a validity marker for the zero, overflow and negative results.

Arithmetic, decimal correction, the stack and instruction decode live outside the block. All updates take effect on the rising clock edge. The interrupt-accept signal and the push image are combinational, so the stacked word already carries the correct break bit in the entry cycle.

Top module: `cpu_status_reg`

## Requirements
- R1: While `rst_n` is low at a rising edge, the register becomes 8'h04, with only the interrupt mask set, and `znv_valid` becomes 1. Reset takes priority over every other input.
- R2: Bit positions in `psr_q` are fixed: bit0 carry, bit1 zero, bit2 interrupt mask, bit3 decimal, bit4 break, bit5 memory-mode, bit6 overflow, bit7 negative. Each `flag_*` output and the mode outputs `decimal_mode` (bit3) and `mem_to_mem` (bit5) equal their bit of `psr_q`.
- R3: With `upd_c` high, carry takes `alu_carry` at the next edge.
- R4: With `upd_zn` high, zero becomes 1 exactly when `alu_res` is 8'h00, and negative takes `alu_res[7]`.
- R5: With `upd_v` high, overflow takes `alu_ovf`.
- R6: With `bit_test` high, negative takes `bit_mem_top[1]` (operand bit 7) and overflow takes `bit_mem_top[0]` (operand bit 6). This overrides an ALU update of those two flags in the same cycle.
- R7: `flag_cmd` codes: 0 none, 1 set carry, 2 clear carry, 3 set mask, 4 clear mask, 5 set decimal, 6 clear decimal, 7 set memory-mode, 8 clear memory-mode, 9 clear overflow. Codes 10 to 15 change nothing. A command overrides ALU and bit-test updates of the same flag. Zero, break and negative have no command.
- R8: `irq_take` = `brk_req` OR (`hw_irq_req` AND NOT interrupt mask). A software break is always accepted.
- R9: In a cycle with `irq_entry` high, `push_val` equals `psr_q` with bit4 replaced by `irq_is_brk`, and break takes `irq_is_brk` at the next edge. Otherwise `push_val` equals `psr_q`.
- R10: Any ALU update (`upd_zn` or `upd_v`) sets `znv_valid` to NOT `alu_dec`. Other cycles leave it unchanged.
- R11: With `load_en` high, the register takes `load_val` and `znv_valid` becomes 1, overriding every flag update in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alu_res | input | 8 | ALU or transfer result for zero/negative |
| alu_carry | input | 1 | Carry or borrow from the ALU |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| alu_dec | input | 1 | Current ALU operation ran in decimal mode |
| upd_c | input | 1 | Update carry strobe |
| upd_zn | input | 1 | Update zero and negative strobe |
| upd_v | input | 1 | Update overflow strobe |
| bit_test | input | 1 | Bit-test operation strobe |
| bit_mem_top | input | 2 | Memory operand bits 7 and 6 |
| flag_cmd | input | 4 | Flag set/clear command code |
| irq_entry | input | 1 | Interrupt entry in this cycle |
| irq_is_brk | input | 1 | Entry is a software break |
| brk_req | input | 1 | Software break request |
| hw_irq_req | input | 1 | Hardware interrupt request |
| load_en | input | 1 | Parallel restore strobe |
| load_val | input | 8 | Value to restore |
| psr_q | output | 8 | Packed register |
| push_val | output | 8 | Image to push to the stack |
| flag_c | output | 1 | Carry |
| flag_z | output | 1 | Zero |
| flag_i | output | 1 | Interrupt mask |
| flag_d | output | 1 | Decimal mode |
| flag_b | output | 1 | Break |
| flag_t | output | 1 | Memory-to-memory mode |
| flag_v | output | 1 | Overflow |
| flag_n | output | 1 | Negative |
| decimal_mode | output | 1 | Decimal arithmetic select |
| mem_to_mem | output | 1 | Memory-to-memory operation select |
| znv_valid | output | 1 | Zero/overflow/negative are valid |
| irq_take | output | 1 | Interrupt accepted |

## Verification
Random cycles drive every strobe, command code and request together, so the bench sees overlaps such as a command hitting the same flag an ALU strobe updates, or a bit test racing an overflow update. These overlaps separate a wrong priority order from a correct one. Directed cases cover the edges of the main function: an all-zero and a negative result, a bit test with operand 8'hC0, unused command codes, a break arriving while interrupts are masked, a decimal operation followed by a binary one, and a restore that coincides with every kind of update. A model of the register in the bench predicts every output in every cycle.

// File: rtl/psr_pkg.sv
// Package: shared constants and types for the status flag register.
// Assumes an eight-bit register whose bit positions never change.
package psr_pkg;
    localparam int PSR_W   = 8;
    localparam int CMD_W   = 4;
    localparam int BIT_C   = 0;
    localparam int BIT_Z   = 1;
    localparam int BIT_I   = 2;
    localparam int BIT_D   = 3;
    localparam int BIT_B   = 4;
    localparam int BIT_T   = 5;
    localparam int BIT_V   = 6;
    localparam int BIT_N   = 7;
    localparam logic [PSR_W-1:0] PSR_RESET = PSR_W'(1) << BIT_I;

    typedef enum logic [CMD_W-1:0] {
        CMD_NONE  = 4'd0,
        CMD_SET_C = 4'd1,
        CMD_CLR_C = 4'd2,
        CMD_SET_I = 4'd3,
        CMD_CLR_I = 4'd4,
        CMD_SET_D = 4'd5,
        CMD_CLR_D = 4'd6,
        CMD_SET_T = 4'd7,
        CMD_CLR_T = 4'd8,
        CMD_CLR_V = 4'd9
    } flag_cmd_e;
endpackage

// File: rtl/psr_cond_flags.sv
// Module: next-state logic for carry, zero, overflow and negative.
// Priority per flag: command over bit test over ALU strobe over hold.
// Assumes at most one command per cycle; purely combinational apart from checks.
module psr_cond_flags
    import psr_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cur_c,
    input  logic             cur_z,
    input  logic             cur_v,
    input  logic             cur_n,
    input  logic [RES_W-1:0] alu_res,
    input  logic             alu_carry,
    input  logic             alu_ovf,
    input  logic             upd_c,
    input  logic             upd_zn,
    input  logic             upd_v,
    input  logic             bit_test,
    input  logic [1:0]       bit_mem_top,
    input  flag_cmd_e        cmd,
    output logic             nxt_c,
    output logic             nxt_z,
    output logic             nxt_v,
    output logic             nxt_n
);
    localparam logic [RES_W-1:0] RES_ZERO = '0;

    // Carry: ALU update, then overridden by its set/clear commands.
    always_comb begin
        nxt_c = cur_c;
        if (upd_c)                nxt_c = alu_carry;
        if (cmd == CMD_SET_C)     nxt_c = 1'b1;
        else if (cmd == CMD_CLR_C) nxt_c = 1'b0;
    end

    // Zero and negative: result test, negative then overridden by bit test.
    always_comb begin
        nxt_z = cur_z;
        nxt_n = cur_n;
        if (upd_zn) begin
            nxt_z = (alu_res == RES_ZERO);
            nxt_n = alu_res[RES_W-1];
        end
        if (bit_test) nxt_n = bit_mem_top[1];
    end

    // Overflow: ALU, then bit test, then the clear command.
    always_comb begin
        nxt_v = cur_v;
        if (upd_v)              nxt_v = alu_ovf;
        if (bit_test)           nxt_v = bit_mem_top[0];
        if (cmd == CMD_CLR_V)   nxt_v = 1'b0;
    end

    p_cmd_clr_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_CLR_V) |-> !nxt_v)
        else $error("clear-overflow command ignored");

    p_bit_n_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_test |-> (nxt_n == bit_mem_top[1]))
        else $error("bit test did not reach negative");
endmodule

// File: rtl/psr_ctrl_flags.sv
// Module: next-state logic for interrupt mask, decimal, break and memory-mode.
// Break follows the interrupt-entry tag; the others follow their commands.
module psr_ctrl_flags
    import psr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cur_i,
    input  logic      cur_d,
    input  logic      cur_b,
    input  logic      cur_t,
    input  flag_cmd_e cmd,
    input  logic      irq_entry,
    input  logic      irq_is_brk,
    output logic      nxt_i,
    output logic      nxt_d,
    output logic      nxt_b,
    output logic      nxt_t
);
    // Control bits: each moves only on its own set or clear code.
    always_comb begin
        nxt_i = cur_i;
        nxt_d = cur_d;
        nxt_t = cur_t;
        unique case (cmd)
            CMD_SET_I: nxt_i = 1'b1;
            CMD_CLR_I: nxt_i = 1'b0;
            CMD_SET_D: nxt_d = 1'b1;
            CMD_CLR_D: nxt_d = 1'b0;
            CMD_SET_T: nxt_t = 1'b1;
            CMD_CLR_T: nxt_t = 1'b0;
            default:   ;
        endcase
    end

    // Break: written only on interrupt entry.
    always_comb begin
        nxt_b = irq_entry ? irq_is_brk : cur_b;
    end

    p_b_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_entry |-> (nxt_b == cur_b))
        else $error("break changed outside entry");
endmodule

// File: rtl/psr_irq_gate.sv
// Module: interrupt acceptance and stack-push image.
// Assumes the break request bypasses the mask; push image is combinational.
module psr_irq_gate
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PSR_W-1:0] psr,
    input  logic             brk_req,
    input  logic             hw_irq_req,
    input  logic             irq_entry,
    input  logic             irq_is_brk,
    output logic             irq_take,
    output logic [PSR_W-1:0] push_val
);
    // Acceptance: break always, hardware only when unmasked.
    always_comb begin
        irq_take = brk_req | (hw_irq_req & ~psr[BIT_I]);
    end

    // Push image: break bit reflects the entry kind during entry.
    always_comb begin
        push_val = psr;
        if (irq_entry) push_val[BIT_B] = irq_is_brk;
    end

    p_brk_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> irq_take)
        else $error("break request not accepted");

    p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (psr[BIT_I] && !brk_req) |-> !irq_take)
        else $error("masked interrupt accepted");
endmodule

// File: rtl/cpu_status_reg.sv
// Module: processor status flag register, top level.
// Holds the packed flags and a validity marker for zero/overflow/negative.
// Assumes one command per cycle; restore overrides all updates; reset wins.
module cpu_status_reg
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       alu_res,
    input  logic             alu_carry,
    input  logic             alu_ovf,
    input  logic             alu_dec,
    input  logic             upd_c,
    input  logic             upd_zn,
    input  logic             upd_v,
    input  logic             bit_test,
    input  logic [1:0]       bit_mem_top,
    input  logic [3:0]       flag_cmd,
    input  logic             irq_entry,
    input  logic             irq_is_brk,
    input  logic             brk_req,
    input  logic             hw_irq_req,
    input  logic             load_en,
    input  logic [7:0]       load_val,
    output logic [7:0]       psr_q,
    output logic [7:0]       push_val,
    output logic             flag_c,
    output logic             flag_z,
    output logic             flag_i,
    output logic             flag_d,
    output logic             flag_b,
    output logic             flag_t,
    output logic             flag_v,
    output logic             flag_n,
    output logic             decimal_mode,
    output logic             mem_to_mem,
    output logic             znv_valid,
    output logic             irq_take
);
    flag_cmd_e        cmd;
    logic [PSR_W-1:0] psr_r;
    logic [PSR_W-1:0] psr_nxt;
    logic             valid_r;
    logic             n_c, n_z, n_v, n_n, n_i, n_d, n_b, n_t;

    assign cmd = flag_cmd_e'(flag_cmd);

    psr_cond_flags #(.RES_W(PSR_W)) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .cur_c      (psr_r[BIT_C]),
        .cur_z      (psr_r[BIT_Z]),
        .cur_v      (psr_r[BIT_V]),
        .cur_n      (psr_r[BIT_N]),
        .alu_res    (alu_res),
        .alu_carry  (alu_carry),
        .alu_ovf    (alu_ovf),
        .upd_c      (upd_c),
        .upd_zn     (upd_zn),
        .upd_v      (upd_v),
        .bit_test   (bit_test),
        .bit_mem_top(bit_mem_top),
        .cmd        (cmd),
        .nxt_c      (n_c),
        .nxt_z      (n_z),
        .nxt_v      (n_v),
        .nxt_n      (n_n)
    );

    psr_ctrl_flags u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_i     (psr_r[BIT_I]),
        .cur_d     (psr_r[BIT_D]),
        .cur_b     (psr_r[BIT_B]),
        .cur_t     (psr_r[BIT_T]),
        .cmd       (cmd),
        .irq_entry (irq_entry),
        .irq_is_brk(irq_is_brk),
        .nxt_i     (n_i),
        .nxt_d     (n_d),
        .nxt_b     (n_b),
        .nxt_t     (n_t)
    );

    psr_irq_gate u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .psr       (psr_r),
        .brk_req   (brk_req),
        .hw_irq_req(hw_irq_req),
        .irq_entry (irq_entry),
        .irq_is_brk(irq_is_brk),
        .irq_take  (irq_take),
        .push_val  (push_val)
    );

    // Pack next-state bits into their fixed positions.
    always_comb begin
        psr_nxt        = '0;
        psr_nxt[BIT_C] = n_c;
        psr_nxt[BIT_Z] = n_z;
        psr_nxt[BIT_I] = n_i;
        psr_nxt[BIT_D] = n_d;
        psr_nxt[BIT_B] = n_b;
        psr_nxt[BIT_T] = n_t;
        psr_nxt[BIT_V] = n_v;
        psr_nxt[BIT_N] = n_n;
    end

    // State register: reset, then restore, then flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psr_r   <= PSR_RESET;
            valid_r <= 1'b1;
        end else if (load_en) begin
            psr_r   <= load_val;
            valid_r <= 1'b1;
        end else begin
            psr_r <= psr_nxt;
            if (upd_zn || upd_v) valid_r <= ~alu_dec;
        end
    end

    // Outputs: packed word, individual flags and mode controls.
    always_comb begin
        psr_q        = psr_r;
        flag_c       = psr_r[BIT_C];
        flag_z       = psr_r[BIT_Z];
        flag_i       = psr_r[BIT_I];
        flag_d       = psr_r[BIT_D];
        flag_b       = psr_r[BIT_B];
        flag_t       = psr_r[BIT_T];
        flag_v       = psr_r[BIT_V];
        flag_n       = psr_r[BIT_N];
        decimal_mode = psr_r[BIT_D];
        mem_to_mem   = psr_r[BIT_T];
        znv_valid    = valid_r;
    end

    p_load_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (psr_q == $past(load_val)) && znv_valid)
        else $error("restore did not take priority");

    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_c && !load_en && cmd != CMD_SET_C && cmd != CMD_CLR_C)
        |=> (flag_c == $past(alu_carry)))
        else $error("carry not updated");

    p_bit_v_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_test && !load_en && cmd != CMD_CLR_V) |=> (flag_v == $past(bit_mem_top[0])))
        else $error("bit test did not reach overflow");

    p_entry_b_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_entry && !load_en) |=> (flag_b == $past(irq_is_brk)))
        else $error("break bit not written on entry");

    p_dec_invalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_zn && alu_dec && !load_en) |=> !znv_valid)
        else $error("decimal result left marked valid");
endmodule

// File: tb/cpu_status_reg_tb.sv
`timescale 1ns/1ps
module cpu_status_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] alu_res;
    logic       alu_carry, alu_ovf, alu_dec, upd_c, upd_zn, upd_v, bit_test;
    logic [1:0] bit_mem_top;
    logic [3:0] flag_cmd;
    logic       irq_entry, irq_is_brk, brk_req, hw_irq_req, load_en;
    logic [7:0] load_val;
    logic [7:0] psr_q, push_val;
    logic       flag_c, flag_z, flag_i, flag_d, flag_b, flag_t, flag_v, flag_n;
    logic       decimal_mode, mem_to_mem, znv_valid, irq_take;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_psr;
    logic       exp_valid;

    always #5 clk = ~clk;

    cpu_status_reg u_dut (.*);

    // Bench model of one clock edge, written from R3..R7, R9..R11.
    function automatic logic [8:0] model_step(input logic [7:0] p, input logic vld);
        logic [7:0] n;
        logic       v;
        n = p;
        v = vld;
        if (load_en) return {1'b1, load_val};
        if (upd_c) n[0] = alu_carry;
        if (upd_zn) begin n[1] = (alu_res == 8'h00); n[7] = alu_res[7]; end
        if (upd_v) n[6] = alu_ovf;
        if (bit_test) begin n[7] = bit_mem_top[1]; n[6] = bit_mem_top[0]; end
        case (flag_cmd)
            4'd1: n[0] = 1'b1;  4'd2: n[0] = 1'b0;
            4'd3: n[2] = 1'b1;  4'd4: n[2] = 1'b0;
            4'd5: n[3] = 1'b1;  4'd6: n[3] = 1'b0;
            4'd7: n[5] = 1'b1;  4'd8: n[5] = 1'b0;
            4'd9: n[6] = 1'b0;
            default: ;
        endcase
        if (irq_entry) n[4] = irq_is_brk;
        if (upd_zn || upd_v) v = ~alu_dec;
        return {v, n};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        alu_res = 8'h00; alu_carry = 0; alu_ovf = 0; alu_dec = 0;
        upd_c = 0; upd_zn = 0; upd_v = 0; bit_test = 0; bit_mem_top = 2'b00;
        flag_cmd = 4'd0; irq_entry = 0; irq_is_brk = 0; brk_req = 0;
        hw_irq_req = 0; load_en = 0; load_val = 8'h00;
    endtask

    // Register outputs against the model (R1/R2 and all register updates).
    task automatic check_regs(input string req);
        chk(req, {24'd0, psr_q}, {24'd0, exp_psr});
        chk(req, {31'd0, znv_valid}, {31'd0, exp_valid});
        chk("R2", {22'd0, flag_n, flag_v, flag_t, flag_b, flag_d, flag_i, flag_z, flag_c,
                   decimal_mode, mem_to_mem}, {22'd0, exp_psr, exp_psr[3], exp_psr[5]});
    endtask

    // One cycle: inputs already set at the falling edge; check comb, clock, check regs.
    task automatic run_cycle(input string req);
        logic [7:0] pv;
        logic [8:0] nx;
        #1;
        pv = exp_psr;
        if (irq_entry) pv[4] = irq_is_brk;
        chk("R9", {24'd0, push_val}, {24'd0, pv});
        chk("R8", {31'd0, irq_take}, {31'd0, brk_req | (hw_irq_req & ~exp_psr[2])});
        nx = model_step(exp_psr, exp_valid);
        @(negedge clk);
        exp_valid = nx[8];
        exp_psr   = nx[7:0];
        check_regs(req);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240517));
        idle_inputs();
        rst_n = 1'b0;
        // R1: reset value, even with a restore pending.
        load_en = 1; load_val = 8'hFF;
        repeat (3) @(negedge clk);
        exp_psr = 8'h04; exp_valid = 1'b1;
        check_regs("R1");
        rst_n = 1'b1;
        idle_inputs();

        // R11: restore beats everything else.
        load_en = 1; load_val = 8'h29; upd_c = 1; alu_carry = 0; upd_zn = 1;
        alu_res = 8'h80; bit_test = 1; bit_mem_top = 2'b11; flag_cmd = 4'd9;
        irq_entry = 1; irq_is_brk = 1; alu_dec = 1;
        run_cycle("R11");
        idle_inputs();

        // R4: zero result, then negative result.
        upd_zn = 1; alu_res = 8'h00; run_cycle("R4");
        upd_zn = 1; alu_res = 8'h9C; run_cycle("R4");
        idle_inputs();

        // R6: bit test with operand 0xC0 over an overflow update of 0.
        bit_test = 1; bit_mem_top = 2'b11; upd_v = 1; alu_ovf = 0; run_cycle("R6");
        idle_inputs();

        // R7: unused codes change nothing; set decimal and memory-mode; clear overflow.
        for (int k = 10; k < 16; k++) begin flag_cmd = 4'(k); run_cycle("R7"); end
        flag_cmd = 4'd5; run_cycle("R7");
        flag_cmd = 4'd7; run_cycle("R7");
        flag_cmd = 4'd9; bit_test = 1; bit_mem_top = 2'b01; run_cycle("R7");
        idle_inputs();

        // R8: break accepted while masked, hardware refused while masked.
        flag_cmd = 4'd3; run_cycle("R7");
        flag_cmd = 4'd0; brk_req = 1; run_cycle("R8");
        brk_req = 0; hw_irq_req = 1; run_cycle("R8");
        flag_cmd = 4'd4; run_cycle("R8");
        flag_cmd = 4'd0; run_cycle("R8");
        idle_inputs();

        // R9: hardware entry clears break, software entry sets it.
        irq_entry = 1; irq_is_brk = 1; run_cycle("R9");
        irq_entry = 1; irq_is_brk = 0; run_cycle("R9");
        idle_inputs();

        // R10: decimal op invalidates, binary op revalidates; R3 carry with clear command.
        upd_zn = 1; alu_dec = 1; alu_res = 8'h15; run_cycle("R10");
        upd_v = 1; alu_dec = 0; run_cycle("R10");
        upd_c = 1; alu_carry = 1; run_cycle("R3");
        upd_c = 1; alu_carry = 1; flag_cmd = 4'd2; run_cycle("R3");
        idle_inputs();

        // Random mix of all inputs (R3..R11).
        for (int i = 0; i < 3000; i++) begin
            alu_res     = 8'($urandom);
            if (($urandom % 4) == 0) alu_res = 8'h00;
            alu_carry   = 1'($urandom);
            alu_ovf     = 1'($urandom);
            alu_dec     = 1'($urandom);
            upd_c       = 1'($urandom);
            upd_zn      = 1'($urandom);
            upd_v       = 1'($urandom);
            bit_test    = (($urandom % 4) == 0);
            bit_mem_top = 2'($urandom);
            flag_cmd    = 4'($urandom);
            irq_entry   = (($urandom % 6) == 0);
            irq_is_brk  = 1'($urandom);
            brk_req     = (($urandom % 5) == 0);
            hw_irq_req  = 1'($urandom);
            load_en     = (($urandom % 16) == 0);
            load_val    = 8'($urandom);
            run_cycle("R5");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule